// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error Retry

This block sends bytes to a smart card over one shared, half-duplex I/O line. Each byte arrives on a valid/ready handshake. The block frames it as a low start bit, eight data bits with the least significant bit first, and an even-parity bit. It then releases the line for a guard time of two bit periods. While the line is released, the card can pull it low to report that it received the character with an error. When that happens the block sends the same character again, up to a programmable number of repeats. A sticky status flag records that the repeat budget was fully used.

The bit period (etu) comes from an external one-cycle tick, `etu_tick`. Every bit and every guard period starts on a tick and lasts until the next tick. The line driver is split into a value, `line_out`, and a drive enable, `line_en`. The pad state is read back on `line_in`.

The state machine has seven states:
- IDLE: ready for a byte.
- ALIGN: a byte has been accepted; waiting for the next tick.
- START: the start bit is on the line.
- DATA: the eight data bits are on the line.
- PARITY: the parity bit is on the line.
- GUARD_A: the line is released; the error signal is sampled at the tick that ends this state.
- GUARD_B: the line is released; the block decides whether to retry.

The transitions are:
- IDLE→ALIGN when a byte is accepted.
- ALIGN→START on a tick.
- START→DATA on a tick.
- DATA→DATA on a tick while bits remain.
- DATA→PARITY on the tick after the last data bit.
- PARITY→GUARD_A on a tick.
- GUARD_A→GUARD_B on a tick.
- GUARD_B→START on a tick when a retry is granted.
- GUARD_B→IDLE on a tick otherwise.

Top module: `sc_char_tx`

## Requirements
- R1: A frame is sent as a low start bit, then 8 data bits with the least significant bit first, then a parity bit equal to the XOR of the data bits (even parity). Each bit is held on `line_out` with `line_en`=1 from one `etu_tick` to the next.
- R2: After the parity bit, `line_en` is 0 for two etu. The line is sampled at the tick that ends the first guard etu, and a low level there counts as an error signal (NACK).
- R3: With `max_iter`=0, every character is sent exactly once, whether or not it is NACKed.
- R4: With `max_iter`=M>0, a NACKed character is repeated until it is acknowledged or until M repeats have been sent, so there are at most M+1 attempts. If the last attempt is also NACKed, the character is dropped. M=7 gives eight attempts.
- R5: An acknowledged attempt ends the retries for that character, and the repeat count starts from zero for the next character.
- R6: `iter_flag` goes to 1 when the repeat count of a character reaches `max_iter` (M>0). It then stays at 1 through later characters.
- R7: `iter_flag` goes to 0 only in the cycle after a one-cycle pulse on `iter_clr`. If a set and a clear fall in the same cycle, the set wins.
- R8: `tx_ready` is 1 only in IDLE, which is reached after the guard time of the final attempt. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both 1.
- R9: After reset, `tx_ready`=1, `line_en`=0, `line_out`=1 and `iter_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block can accept a byte |
| max_iter | input | 3 | Repeat limit (0 = no retry) |
| iter_clr | input | 1 | Pulse that clears `iter_flag` |
| iter_flag | output | 1 | Sticky flag: the repeat limit was reached |
| line_in | input | 1 | Level read back from the I/O line |
| line_out | output | 1 | Value driven onto the line |
| line_en | output | 1 | Drive enable for the line (0 = released) |

## Verification
The bench plays the card and NACKs a chosen number of attempts for each byte. It covers a zero limit, a NACK count below the limit, a NACK count equal to the limit, a NACK count above the limit, and the full eight-attempt case. Each case has a distinct failure mode in a wrong design:
- An off-by-one repeat test sends one attempt too many or too few.
- A zero limit treated as unlimited loops on a NACK.
- A repeat counter that is not cleared on acknowledge gives the next byte a short retry budget and sets the flag early.
- A flag that is not sticky, or that clears on its own, shows the wrong level after an acknowledged byte or after the clear pulse.

Driving during the guard window would hide the card's NACK. The bench checks `line_en` inside that window.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GUARD_A,
        ST_GUARD_B
    } tx_state_e;
endpackage

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter #(
    parameter int DATA_BITS = 8,
    localparam int IDX_W = $clog2(DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 idx_clr,
    input  logic                 adv,
    input  logic                 sel_par,
    output logic                 bit_val,
    output logic                 last_bit
);
    logic [DATA_BITS-1:0] byte_q;
    logic [IDX_W-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
        end else begin
            if (load)
                byte_q <= din;
            if (idx_clr)
                idx_q <= '0;
            else if (adv)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        last_bit = (idx_q == IDX_W'(DATA_BITS - 1));
        bit_val  = sel_par ? (^byte_q) : byte_q[idx_q];
    end

    // R1: the bit index never steps past the last data bit
    p_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !last_bit);
endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] max_iter,
    input  logic             decide,
    input  logic             nack,
    input  logic             iter_clr,
    output logic             retry,
    output logic             iter_flag
);
    logic [CNT_W-1:0] rep_q;
    logic             hit_max;

    always_comb begin
        retry   = nack && (max_iter != '0) && (rep_q < max_iter);
        hit_max = decide && retry && ((rep_q + 1'b1) == max_iter);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q     <= '0;
            iter_flag <= 1'b0;
        end else begin
            if (decide)
                rep_q <= retry ? rep_q + 1'b1 : '0;
            if (hit_max)
                iter_flag <= 1'b1;
            else if (iter_clr)
                iter_flag <= 1'b0;
        end
    end

    // R3: a zero limit never grants a repeat
    p_no_retry_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (max_iter == '0) |-> !retry);
    // R6: flag stays set unless a clear arrives
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_flag && !iter_clr) |=> iter_flag);
    // R7: a clear with no competing set empties the flag
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_clr && !hit_max) |=> !iter_flag);
    // R5: an acknowledged decision returns the count to zero
    p_cnt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !nack) |=> (rep_q == '0));
endmodule

// File: rtl/sc_tx_fsm.sv
module sc_tx_fsm
    import sc_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic tx_valid,
    input  logic last_bit,
    input  logic retry,
    input  logic line_in,
    output logic tx_ready,
    output logic load,
    output logic idx_clr,
    output logic adv,
    output logic drive_en,
    output logic drive_start,
    output logic drive_par,
    output logic decide,
    output logic nack
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nack    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_GUARD_A && etu_tick)
                nack <= !line_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tx_valid) state_d = ST_ALIGN;
            ST_ALIGN:   if (etu_tick) state_d = ST_START;
            ST_START:   if (etu_tick) state_d = ST_DATA;
            ST_DATA:    if (etu_tick && last_bit) state_d = ST_PARITY;
            ST_PARITY:  if (etu_tick) state_d = ST_GUARD_A;
            ST_GUARD_A: if (etu_tick) state_d = ST_GUARD_B;
            ST_GUARD_B: if (etu_tick) state_d = retry ? ST_START : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_ready    = (state_q == ST_IDLE);
        load        = tx_ready && tx_valid;
        idx_clr     = (state_q == ST_START);
        adv         = (state_q == ST_DATA) && etu_tick && !last_bit;
        drive_start = (state_q == ST_START);
        drive_par   = (state_q == ST_PARITY);
        drive_en    = drive_start || drive_par || (state_q == ST_DATA);
        decide      = (state_q == ST_GUARD_B) && etu_tick;
    end

    // R8: accepting a byte always leaves idle
    p_accept_leaves_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tx_ready);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
    parameter int DATA_BITS = 8,
    parameter int CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 etu_tick,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic [CNT_W-1:0]     max_iter,
    input  logic                 iter_clr,
    output logic                 iter_flag,
    input  logic                 line_in,
    output logic                 line_out,
    output logic                 line_en
);
    logic load, idx_clr, adv, drive_en, drive_start, drive_par;
    logic decide, nack, retry, bit_val, last_bit;

    sc_tx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .tx_valid(tx_valid),
        .last_bit(last_bit), .retry(retry), .line_in(line_in),
        .tx_ready(tx_ready), .load(load), .idx_clr(idx_clr), .adv(adv),
        .drive_en(drive_en), .drive_start(drive_start), .drive_par(drive_par),
        .decide(decide), .nack(nack)
    );

    sc_tx_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .din(tx_data),
        .idx_clr(idx_clr), .adv(adv), .sel_par(drive_par),
        .bit_val(bit_val), .last_bit(last_bit)
    );

    sc_tx_retry #(.CNT_W(CNT_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .max_iter(max_iter), .decide(decide),
        .nack(nack), .iter_clr(iter_clr), .retry(retry), .iter_flag(iter_flag)
    );

    always_comb begin
        line_en  = drive_en;
        line_out = drive_en ? (drive_start ? 1'b0 : bit_val) : 1'b1;
    end

    // R1: the line only changes on a bit-period boundary or a byte acceptance
    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !etu_tick |=> ($stable(line_en) && $stable(line_out)));
    // R2: the retry decision is taken with the line released
    p_quiet_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> !line_en);
    // R8: ready never overlaps driving the line
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !line_en);
endmodule

// File: tb/test_sc_char_tx.sv
module test_sc_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       etu_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [2:0] max_iter = 3'd0;
    logic       iter_clr = 1'b0;
    logic       iter_flag;
    logic       line_in;
    logic       line_out;
    logic       line_en;
    logic       card_low = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_flag = 1'b0;
    logic [7:0] exp_data[$];
    bit         exp_nack[$];

    always #10 clk = ~clk;

    assign line_in = line_en ? line_out : ~card_low;

    sc_char_tx i_sc_char_tx (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .max_iter(max_iter),
        .iter_clr(iter_clr), .iter_flag(iter_flag), .line_in(line_in),
        .line_out(line_out), .line_en(line_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            etu_tick = 1'b1;
            @(negedge clk);
            etu_tick = 1'b0;
        end
    end

    // Monitor: acts as the card and compares every frame to the scoreboard
    initial begin
        forever begin
            logic [7:0] got;
            logic       par;
            logic [7:0] want;
            bit         do_nack;
            @(negedge clk);
            if (line_en && !line_out) begin
                for (int i = 0; i < 8; i++) begin
                    repeat (4) @(negedge clk);
                    got[i] = line_out;
                    chk(line_en == 1'b1, "R1", "drive during data", line_en, 1);
                end
                repeat (4) @(negedge clk);
                par = line_out;
                chk(line_en == 1'b1, "R1", "drive during parity", line_en, 1);
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R4", "unexpected extra frame", got, 0);
                    do_nack = 1'b0;
                end else begin
                    want    = exp_data.pop_front();
                    do_nack = exp_nack.pop_front();
                    chk(got == want, "R1", "frame data", got, want);
                    chk(par == ^want, "R1", "even parity bit", par, ^want);
                end
                repeat (4) @(negedge clk);
                chk(line_en == 1'b0, "R2", "line released in guard", line_en, 0);
                card_low = do_nack;
                repeat (4) @(negedge clk);
                card_low = 1'b0;
                chk(line_en == 1'b0, "R2", "line released in second guard", line_en, 0);
            end
        end
    end

    // Driver: queues expected attempts, hands the byte over, waits for idle
    task automatic send(input logic [7:0] d, input int nacks, input string req);
        int m = int'(max_iter);
        int att = (m == 0) ? 1 : ((nacks > m) ? m + 1 : nacks + 1);
        for (int a = 0; a < att; a++) begin
            exp_data.push_back(d);
            exp_nack.push_back(a < nacks);
        end
        if (m > 0 && nacks >= m)
            exp_flag = 1'b1;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R8", "ready low after accept", tx_ready, 0);
        while (!tx_ready) @(negedge clk);
        chk(exp_data.size() == 0, req, "attempts left unsent", exp_data.size(), 0);
        chk(iter_flag == exp_flag, "R6", "iteration flag", iter_flag, exp_flag);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        iter_clr = 1'b1;
        @(negedge clk);
        iter_clr = 1'b0;
        exp_flag = 1'b0;
        chk(iter_flag == 1'b0, "R7", "flag after clear pulse", iter_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(tx_ready == 1'b1, "R9", "ready at reset", tx_ready, 1);
        chk(line_en == 1'b0, "R9", "line released at reset", line_en, 0);
        chk(line_out == 1'b1, "R9", "line high at reset", line_out, 1);
        chk(iter_flag == 1'b0, "R9", "flag at reset", iter_flag, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        max_iter = 3'd0;
        send(8'hA5, 0, "R1");
        send(8'h3C, 2, "R3");      // R3: NACKs ignored with zero limit
        max_iter = 3'd3;
        send(8'h81, 1, "R5");      // R5: acked on the first repeat
        send(8'h7E, 3, "R4");      // R6: limit reached, flag set
        send(8'h00, 0, "R6");      // R6: flag still set
        clear_flag();              // R7
        send(8'h11, 0, "R7");      // R7: stays clear without a new set
        max_iter = 3'd2;
        send(8'hFF, 5, "R4");      // R4: dropped after max+1 attempts
        clear_flag();
        max_iter = 3'd7;
        send(8'h5A, 7, "R4");      // R4: eight attempts in total
        clear_flag();
        max_iter = 3'd2;
        send(8'h02, 1, "R5");
        send(8'h04, 2, "R5");      // R5: full budget available again
        send(8'hC3, 0, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule